// File: doc/BRIEF.md
# Shift Unit with Carry-Out

This block is the shifter stage of a 32-bit compact-encoding integer datapath. One operand is shifted left logically, right logically, right arithmetically or rotated right. The shift amount comes from one of two places: a 5-bit field carried in the instruction, or the low byte of a register value. The block returns the shifted word, a carry-out, the negative and zero flags, and a strobe that says whether the carry was newly defined by the shift. When the shift defines no new carry, the incoming carry is passed through unchanged.

The architectural corner cases are handled in full: amounts of zero, amounts of exactly the word width, and amounts beyond it. In the immediate form, a zero amount on a right shift means a shift by the full width. The result is captured in one output register together with a single-cycle valid pulse, so results come out one per accepted request.

Top module: `shift_unit`

## Requirements
- R1: `in_kind` selects the operation: 0 = LSL, 1 = LSR, 2 = ASR, 3 = ROR. `in_src` = 0 takes the amount from `in_imm`, and `in_src` = 1 takes it from `in_reg_amt`. Only bits 7:0 of `in_reg_amt` are used; bits 31:8 have no effect on any output.
- R2: LSL by 1 to 31 gives the operand shifted left. The carry is operand bit (32 − amount).
- R3: LSR and ASR by 1 to 31 give the operand shifted right, with zero fill for LSR and sign fill for ASR. The carry is operand bit (amount − 1).
- R4: LSL by exactly 32 gives zero with carry = operand bit 0. LSL by more than 32 gives zero with carry 0.
- R5: LSR by exactly 32 gives zero with carry = operand bit 31. LSR by more than 32 gives zero with carry 0. In both cases N = 0 and Z = 1.
- R6: ASR by 32 or more sets every result bit to the operand's bit 31, and the carry equals that bit.
- R7: A register amount whose low byte is zero passes the operand and `in_carry` through unchanged, with `out_c_upd` = 0. N and Z still follow the operand.
- R8: An immediate LSR or ASR amount of 0 is a shift by 32. An immediate LSL amount of 0 is a plain move: the carry is unchanged and `out_c_upd` = 0.
- R9: ROR uses the amount modulo 32, and the carry is result bit 31. A nonzero register amount with zero low five bits leaves the operand unchanged, with carry = operand bit 31. An immediate ROR amount of 0 behaves as in R7.
- R10: `out_neg` equals result bit 31, and `out_zero` is 1 exactly when the result is zero. `out_c_upd` is 1 whenever the carry was defined by the shift.
- R11: The outputs load on the rising edge at which `in_valid` is 1. `out_valid` is high for exactly the cycle after each accepted request. A synchronous active-low reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_data | input | 32 | Operand to shift |
| in_kind | input | 2 | Shift type (0 LSL, 1 LSR, 2 ASR, 3 ROR) |
| in_src | input | 1 | Amount source: 0 immediate, 1 register |
| in_imm | input | 5 | Immediate amount |
| in_reg_amt | input | 32 | Register amount; only bits 7:0 used |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result strobe, one cycle per request |
| out_data | output | 32 | Shifted result |
| out_carry | output | 1 | Carry-out |
| out_neg | output | 1 | Negative flag |
| out_zero | output | 1 | Zero flag |
| out_c_upd | output | 1 | Carry was defined by this shift |

## Verification
Every shift type is swept over all 32 immediate amounts and over register amounts 0 to 40 plus 63, 64, 96 and 255. Each point is run against five operands and both incoming carry values. The operands include all-zero, all-one, and words with only the end bits set or clear, so that the fill direction, the carry bit index and the pass-through of the carry are each visible. A second sweep puts junk in the upper bits of the register amount, including low-byte values of zero and 32, to show that only the low byte counts. The expected values come from a model that moves the operand one bit per step and takes the carry from the bit that falls off. This approach is unrelated to the single-step formulation in the design.

// File: rtl/shift_unit.sv
module shift_unit #(
  parameter int W  = 32,
  parameter int AW = 8,
  localparam int SW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [W-1:0]  in_data,
  input  logic [1:0]    in_kind,
  input  logic          in_src,
  input  logic [SW-1:0] in_imm,
  input  logic [W-1:0]  in_reg_amt,
  input  logic          in_carry,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          out_carry,
  output logic          out_neg,
  output logic          out_zero,
  output logic          out_c_upd
);
  localparam logic [1:0] K_LSL = 2'd0;
  localparam logic [1:0] K_LSR = 2'd1;
  localparam logic [1:0] K_ASR = 2'd2;
  localparam logic [1:0] K_ROR = 2'd3;

  logic [AW-1:0] amt;
  logic [W:0]    lsl_ext, lsr_ext, asr_ext;
  logic [W-1:0]  rot;
  logic [SW-1:0] rk;
  logic [W-1:0]  res;
  logic          cy, upd;
  logic          unused_hi;

  assign unused_hi = ^in_reg_amt[W-1:AW];

  always_comb begin
    if (in_src)
      amt = in_reg_amt[AW-1:0];
    else if ((in_kind == K_LSR || in_kind == K_ASR) && in_imm == '0)
      amt = AW'(W);
    else
      amt = AW'(in_imm);
  end

  assign rk      = amt[SW-1:0];
  assign lsl_ext = {1'b0, in_data} << amt;
  assign lsr_ext = {in_data, 1'b0} >> amt;
  assign asr_ext = $signed({in_data, 1'b0}) >>> amt;
  assign rot     = (in_data >> rk) | (in_data << (W - 32'(rk)));

  always_comb begin
    res = in_data;
    cy  = in_carry;
    upd = 1'b0;
    if (amt != '0) begin
      upd = 1'b1;
      case (in_kind)
        K_LSL: begin res = lsl_ext[W-1:0]; cy = lsl_ext[W]; end
        K_LSR: begin res = lsr_ext[W:1];   cy = lsr_ext[0]; end
        K_ASR: begin res = asr_ext[W:1];   cy = asr_ext[0]; end
        default: begin res = rot;          cy = rot[W-1];   end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_carry <= 1'b0;
      out_neg   <= 1'b0;
      out_zero  <= 1'b0;
      out_c_upd <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= res;
        out_carry <= cy;
        out_neg   <= res[W-1];
        out_zero  <= (res == '0);
        out_c_upd <= upd;
      end
    end
  end
endmodule

module shift_unit_chk #(
  parameter int W  = 32,
  parameter int AW = 8,
  localparam int SW = $clog2(W)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [W-1:0]  in_data,
  input logic [1:0]    in_kind,
  input logic          in_src,
  input logic [SW-1:0] in_imm,
  input logic [W-1:0]  in_reg_amt,
  input logic          in_carry,
  input logic          out_valid,
  input logic [W-1:0]  out_data,
  input logic          out_carry,
  input logic          out_neg,
  input logic          out_zero,
  input logic          out_c_upd
);
  // R11
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !out_valid && out_data == '0);
  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid);
  // R11
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid);
  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_zero == (out_data == '0)) && (out_neg == out_data[W-1]));
  // R7
  reg_zero_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_src && in_reg_amt[AW-1:0] == '0 |=>
      out_data == $past(in_data) && out_carry == $past(in_carry) && !out_c_upd);
  // R8
  imm_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_src && in_kind == 2'd0 && in_imm == '0 |=>
      out_data == $past(in_data) && out_carry == $past(in_carry) && !out_c_upd);
  // R5
  lsr_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_src && in_kind == 2'd1 && in_reg_amt[AW-1:0] >= AW'(W) |=>
      out_data == '0 && out_zero && !out_neg && out_c_upd);
  // R6
  asr_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_src && in_kind == 2'd2 && in_reg_amt[AW-1:0] >= AW'(W) |=>
      out_carry == $past(in_data[W-1]) && out_data == {W{$past(in_data[W-1])}});
endmodule

bind shift_unit shift_unit_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_kind(in_kind), .in_src(in_src), .in_imm(in_imm), .in_reg_amt(in_reg_amt),
  .in_carry(in_carry), .out_valid(out_valid), .out_data(out_data),
  .out_carry(out_carry), .out_neg(out_neg), .out_zero(out_zero),
  .out_c_upd(out_c_upd)
);

// File: tb/tb_shift_unit.sv
module tb_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic [1:0]  in_kind = '0;
  logic        in_src = 1'b0;
  logic [4:0]  in_imm = '0;
  logic [31:0] in_reg_amt = '0;
  logic        in_carry = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;
  logic        out_carry, out_neg, out_zero, out_c_upd;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  shift_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_kind(in_kind), .in_src(in_src), .in_imm(in_imm), .in_reg_amt(in_reg_amt),
    .in_carry(in_carry), .out_valid(out_valid), .out_data(out_data),
    .out_carry(out_carry), .out_neg(out_neg), .out_zero(out_zero),
    .out_c_upd(out_c_upd)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run did not finish (actual cycles %0d, expected < 150000)", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  function automatic logic [33:0] model(input logic [1:0] k, input logic src,
      input logic [4:0] imm, input logic [31:0] ra, input logic [31:0] x, input logic ci);
    int n;
    logic [31:0] r;
    logic c;
    r = x;
    c = ci;
    if (src) n = int'(ra[7:0]);
    else if ((k == 2'd1 || k == 2'd2) && imm == 5'd0) n = 32;
    else n = int'(imm);
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin c = r[31]; r = {r[30:0], 1'b0}; end
        2'd1: begin c = r[0];  r = {1'b0, r[31:1]}; end
        2'd2: begin c = r[0];  r = {r[31], r[31:1]}; end
        default: begin c = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
    return {(n != 0), c, r};
  endfunction

  function automatic string tag_of(input logic [1:0] k, input logic src,
      input logic [4:0] imm, input logic [31:0] ra);
    int n;
    if (src) n = int'(ra[7:0]);
    else if ((k == 2'd1 || k == 2'd2) && imm == 5'd0) return "R8";
    else n = int'(imm);
    if (n == 0) return src ? "R7" : (k == 2'd3 ? "R9" : "R8");
    case (k)
      2'd0: return (n < 32) ? "R2" : "R4";
      2'd1: return (n < 32) ? "R3" : "R5";
      2'd2: return (n < 32) ? "R3" : "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic run(input logic [1:0] k, input logic src, input logic [4:0] imm,
      input logic [31:0] ra, input logic [31:0] x, input logic ci, input string tag);
    logic [33:0] e;
    e = model(k, src, imm, ra, x, ci);
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_src = src; in_imm = imm;
    in_reg_amt = ra; in_data = x; in_carry = ci;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (!out_valid || out_data !== e[31:0] || out_carry !== e[32] || out_c_upd !== e[33]) begin
      failures++;
      $display("FAIL %s k=%0d src=%0d imm=%0d ra=%h x=%h: actual v=%b d=%h c=%b u=%b expected v=1 d=%h c=%b u=%b",
        tag, k, src, imm, ra, x, out_valid, out_data, out_carry, out_c_upd, e[31:0], e[32], e[33]);
    end
    checks++;
    if (out_neg !== e[31] || out_zero !== (e[31:0] == 32'd0)) begin
      failures++;
      $display("FAIL R10 flags: actual n=%b z=%b expected n=%b z=%b",
        out_neg, out_zero, e[31], (e[31:0] == 32'd0));
    end
  endtask

  logic [31:0] ops [5];
  int ramts [45];

  initial begin
    ops[0] = 32'h8000_0001; ops[1] = 32'h7FFF_FFFE; ops[2] = 32'hA5A5_3C3C;
    ops[3] = 32'h0000_0000; ops[4] = 32'hFFFF_FFFF;
    for (int i = 0; i <= 40; i++) ramts[i] = i;
    ramts[41] = 63; ramts[42] = 64; ramts[43] = 96; ramts[44] = 255;

    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 32'd0 || out_carry !== 1'b0) begin
      failures++;
      $display("FAIL R11 reset state: actual v=%b d=%h c=%b expected v=0 d=0 c=0",
        out_valid, out_data, out_carry);
    end
    rst_n = 1'b1;

    for (int k = 0; k < 4; k++)
      for (int o = 0; o < 5; o++)
        for (int ci = 0; ci < 2; ci++) begin
          for (int a = 0; a < 32; a++)
            run(2'(k), 1'b0, 5'(a), 32'h0, ops[o], 1'(ci), tag_of(2'(k), 1'b0, 5'(a), 32'h0));
          for (int a = 0; a < 45; a++)
            run(2'(k), 1'b1, 5'd0, 32'(ramts[a]), ops[o], 1'(ci),
                tag_of(2'(k), 1'b1, 5'd0, 32'(ramts[a])));
        end

    for (int k = 0; k < 4; k++)
      for (int a = 0; a < 40; a += 4) begin
        run(2'(k), 1'b1, 5'd0, 32'hDEAD_BE00 | 32'(a), 32'hC001_0003, a[2], "R1");
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
          failures++;
          $display("FAIL R11 pulse length: actual out_valid=%b expected 0", out_valid);
        end
      end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule